// File: doc/BRIEF.md
# Two-Wire Bus Byte Shift Register

This block is the data path for one byte on a two-wire serial bus. It is used both to send and to receive. Software or a controller loads a byte in parallel. A drive strobe, issued while the clock line is low, puts the register's most significant bit on the serial output. A sample strobe, issued on each clock-line rising edge, shifts the register left by one place and takes the sampled data line into the least significant bit.

Because the register takes in the line even while it sends, it always holds the byte that actually appeared on the bus. A master that loses arbitration part way through a byte can therefore carry on as a slave receiver. The register already holds the correct data, so nothing needs to be reloaded.

Arbitration loss is detected when the block, acting as master, drives a 1 but samples a 0. The loss is then held, and the serial output stays released (1) until the next parallel load. A bit counter marks the end of each eight-bit byte. The acknowledge bit is handled elsewhere and never enters this register.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset `sda_out` is 1, `rd_data` is 0, and `byte_done` and `arb_lost` are 0.
- R2: When `load_en` is 1, `rd_data` equals `load_data` after the next clock edge. This holds even if `sample_en` is 1 in the same cycle, and the load wins over the shift.
- R3: When `sample_en` is 1 and `load_en` is 0, after the next edge the register holds its old bits 6..0 in bits 7..1 and `sda_in` in bit 0.
- R4: Bus bits are shifted in while the block transmits. After eight samples `rd_data` equals the byte seen on the bus, with the first bus bit in bit 7, whatever byte was loaded.
- R5: On a `drive_en` cycle, `sda_out` takes register bit 7 when `tx_mode` is 1 and arbitration is not lost, and 1 otherwise. `sda_out` does not change between drive strobes.
- R6: When `tx_mode` is 1, `sda_out` is 1 and a sample strobe sees `sda_in` at 0, `arb_lost` is 1 from the next edge. It stays 1 until a parallel load clears it.
- R7: While `arb_lost` is 1, `sda_out` is 1 for the rest of the byte, including every later drive strobe.
- R8: `byte_done` is 1 for exactly one clock after every eighth sample strobe. Counting restarts after that pulse, and a parallel load sets the count back to zero.
- R9: With neither `load_en` nor `sample_en` active, `rd_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Parallel load strobe |
| load_data | input | 8 | Byte to load |
| sample_en | input | 1 | Bit-sample strobe (clock-line rising edge) |
| drive_en | input | 1 | Bit-drive strobe (clock-line low phase) |
| sda_in | input | 1 | Synchronised data-line value |
| tx_mode | input | 1 | 1 when transmitting as master |
| sda_out | output | 1 | Serial data to the open-drain driver, 1 means released |
| rd_data | output | 8 | Register contents |
| byte_done | output | 1 | One-clock pulse after the eighth sample |
| arb_lost | output | 1 | Sticky arbitration-loss flag |

## Verification
The checker watches every cycle for the following properties:
- the one-place shift with the sampled bit entering bit 0;
- load priority, and the flag clearing that comes with a load;
- a held register when no strobe is active;
- the sticky loss flag, and that it rises only on a master sample of 0;
- the released output while the flag is set;
- the single-cycle width of the done pulse.

Some behaviours only the bench's scenarios can show:
- that a full byte received under transmission equals the bus byte;
- that the pulse comes exactly on the eighth sample;
- that a loss on the last bit or on the second bit leaves the correct data behind.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef struct packed {
      logic load;
      logic sample;
      logic drive;
   } bsr_strobe_t;

   function automatic int unsigned bsr_cnt_width(input int unsigned bits);
      return (bits <= 2) ? 1 : $clog2(bits);
   endfunction
endpackage

// File: rtl/bsr_shift_core.sv
module bsr_shift_core
   import bsr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bsr_strobe_t       stb,
   input  logic [DATA_W-1:0] par_in,
   input  logic              ser_in,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] nxt;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == 0) begin : g_lsb
            always_comb begin
               if (stb.load)        nxt[b] = par_in[b];
               else if (stb.sample) nxt[b] = ser_in;
               else                 nxt[b] = q[b];
            end
         end else begin : g_upper
            always_comb begin
               if (stb.load)        nxt[b] = par_in[b];
               else if (stb.sample) nxt[b] = q[b-1];
               else                 nxt[b] = q[b];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/bsr_bit_counter.sv
module bsr_bit_counter
   import bsr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  bsr_strobe_t stb,
   output logic        done
);
   localparam int unsigned CNT_W = bsr_cnt_width(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (stb.load) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (stb.sample) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            done <= 1'b1;
         end else begin
            cnt  <= cnt + 1'b1;
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end
endmodule

// File: rtl/bsr_arb_monitor.sv
module bsr_arb_monitor
   import bsr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  bsr_strobe_t stb,
   input  logic        tx_mode,
   input  logic        msb,
   input  logic        sda_in,
   output logic        sda_out,
   output logic        lost
);
   logic lost_set;

   assign lost_set = stb.sample && !stb.load && tx_mode && sda_out && !sda_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lost    <= 1'b0;
         sda_out <= 1'b1;
      end else begin
         if (stb.load)     lost <= 1'b0;
         else if (lost_set) lost <= 1'b1;

         if (lost_set)       sda_out <= 1'b1;
         else if (stb.drive) sda_out <= (tx_mode && !lost) ? msb : 1'b1;
      end
   end
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
   import bsr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_data,
   input  logic              sample_en,
   input  logic              drive_en,
   input  logic              sda_in,
   input  logic              tx_mode,
   output logic              sda_out,
   output logic [DATA_W-1:0] rd_data,
   output logic              byte_done,
   output logic              arb_lost
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("i2c_byte_shifter: DATA_W must be at least 2");
      end
   endgenerate

   bsr_strobe_t stb;
   assign stb = '{load: load_en, sample: sample_en, drive: drive_en};

   bsr_shift_core #(.DATA_W(DATA_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (stb),
      .par_in (load_data),
      .ser_in (sda_in),
      .q      (rd_data)
   );

   bsr_bit_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (stb),
      .done  (byte_done)
   );

   bsr_arb_monitor u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (stb),
      .tx_mode (tx_mode),
      .msb     (rd_data[DATA_W-1]),
      .sda_in  (sda_in),
      .sda_out (sda_out),
      .lost    (arb_lost)
   );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_en,
   input logic [DATA_W-1:0] load_data,
   input logic              sample_en,
   input logic              drive_en,
   input logic              sda_in,
   input logic              tx_mode,
   input logic              sda_out,
   input logic [DATA_W-1:0] rd_data,
   input logic              byte_done,
   input logic              arb_lost
);
   assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (rd_data == $past(load_data)) && !byte_done && !arb_lost);

   assert_shift_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !load_en) |=>
         (rd_data == {$past(rd_data[DATA_W-2:0]), $past(sda_in)}));

   assert_loss_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost && !load_en) |=> arb_lost);

   assert_loss_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!arb_lost && !load_en && !(sample_en && tx_mode && !sda_in)) |=> !arb_lost);

   assert_released_after_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> sda_out);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !sample_en) |=> $stable(rd_data));

   assert_out_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive_en && !sample_en) |=> $stable(sda_out));
endmodule

bind i2c_byte_shifter bsr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
   .sample_en(sample_en), .drive_en(drive_en), .sda_in(sda_in),
   .tx_mode(tx_mode), .sda_out(sda_out), .rd_data(rd_data),
   .byte_done(byte_done), .arb_lost(arb_lost)
);

// File: tb/sim_i2c_byte_shifter.sv
`timescale 1ns/1ps
module sim_i2c_byte_shifter;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       load_en, sample_en, drive_en, sda_in, tx_mode;
   logic [7:0] load_data;
   logic       sda_out, byte_done, arb_lost;
   logic [7:0] rd_data;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   i2c_byte_shifter u0 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
      .sample_en(sample_en), .drive_en(drive_en), .sda_in(sda_in),
      .tx_mode(tx_mode), .sda_out(sda_out), .rd_data(rd_data),
      .byte_done(byte_done), .arb_lost(arb_lost)
   );

   // fields: tx byte, bus byte, tx_mode, expected rd_data, expected arb_lost
   localparam int NV = 5;
   localparam logic [25:0] VEC [NV] = '{
      {8'hA5, 8'hA5, 1'b1, 8'hA5, 1'b0},
      {8'hFF, 8'h3C, 1'b0, 8'h3C, 1'b0},
      {8'hF0, 8'hB0, 1'b1, 8'hB0, 1'b1},
      {8'h00, 8'h00, 1'b1, 8'h00, 1'b0},
      {8'h81, 8'h80, 1'b1, 8'h80, 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic ld, input logic [7:0] d, input logic smp,
                       input logic drv, input logic sda, input logic tx);
      @(negedge clk);
      load_en = ld; load_data = d; sample_en = smp;
      drive_en = drv; sda_in = sda; tx_mode = tx;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] tx_b, bus_b, exp_rd_t, model;
      logic       txm, exp_arb_t, lost, exp_o;
      rst_n = 1'b0;
      load_en = 0; load_data = 0; sample_en = 0; drive_en = 0; sda_in = 1; tx_mode = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 sda_out", {7'd0, sda_out}, 8'd1);
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 byte_done", {7'd0, byte_done}, 8'd0);
      chk("R1 arb_lost", {7'd0, arb_lost}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         {tx_b, bus_b, txm, exp_rd_t, exp_arb_t} = VEC[v];
         step(1, tx_b, 0, 0, 1, txm);
         chk("R2 load", rd_data, tx_b);
         model = tx_b;
         lost = 1'b0;
         for (int i = 7; i >= 0; i--) begin
            step(0, 8'h00, 0, 1, 1, txm);
            exp_o = (txm && !lost) ? model[7] : 1'b1;
            chk("R5 R7 sda_out on drive", {7'd0, sda_out}, {7'd0, exp_o});
            step(0, 8'h00, 1, 0, bus_b[i], txm);
            if (txm && exp_o && !bus_b[i]) lost = 1'b1;
            model = {model[6:0], bus_b[i]};
            chk("R3 shift", rd_data, model);
            chk("R6 arb_lost", {7'd0, arb_lost}, {7'd0, lost});
            chk("R8 byte_done", {7'd0, byte_done}, {7'd0, (i == 0)});
         end
         chk("R4 bus byte", rd_data, exp_rd_t);
         chk("R6 final arb", {7'd0, arb_lost}, {7'd0, exp_arb_t});
         step(0, 8'h00, 0, 0, 1, txm);
         chk("R8 done falls", {7'd0, byte_done}, 8'd0);
         chk("R9 idle hold", rd_data, exp_rd_t);
         chk("R7 released", {7'd0, sda_out}, exp_arb_t ? 8'd1 : {7'd0, sda_out});
      end

      // R6 load clears a held loss (previous row ended lost)
      step(1, 8'h3E, 0, 0, 1, 1);
      chk("R6 cleared by load", {7'd0, arb_lost}, 8'd0);

      // R2 load wins over a same-cycle sample; count restarts
      step(0, 8'h00, 1, 0, 0, 0);
      step(0, 8'h00, 1, 0, 0, 0);
      step(1, 8'hC3, 1, 0, 0, 0);
      chk("R2 priority", rd_data, 8'hC3);
      for (int k = 0; k < 7; k++) step(0, 8'h00, 1, 0, 1, 0);
      chk("R8 count reset by load", {7'd0, byte_done}, 8'd0);
      chk("R3 seven ones", rd_data, 8'hFF);
      step(0, 8'h00, 1, 0, 0, 0);
      chk("R8 eighth sample", {7'd0, byte_done}, 8'd1);
      chk("R3 last bit", rd_data, 8'hFE);
      // second byte without reload: pulse again on the sixteenth sample
      for (int k = 0; k < 7; k++) step(0, 8'h00, 1, 0, 0, 0);
      chk("R8 no early pulse", {7'd0, byte_done}, 8'd0);
      step(0, 8'h00, 1, 0, 1, 0);
      chk("R8 second byte", {7'd0, byte_done}, 8'd1);
      chk("R4 second byte data", rd_data, 8'h01);

      // R5 drive while not master keeps line released
      step(1, 8'h00, 0, 0, 1, 0);
      step(0, 8'h00, 0, 1, 1, 0);
      chk("R5 receive drive", {7'd0, sda_out}, 8'd1);
      // R5 no change between drive strobes
      step(0, 8'h00, 0, 1, 1, 1);
      chk("R5 master drive 0", {7'd0, sda_out}, 8'd0);
      step(0, 8'hFF, 0, 0, 1, 1);
      chk("R5 hold between strobes", {7'd0, sda_out}, 8'd0);
      chk("R9 strobes idle", rd_data, 8'h00);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule